// File: doc/BRIEF.md
# Neural Multiply-Accumulate Processing Element

This block is one cell of a two-dimensional neural-network array. Each cell keeps a private store of signed 16-bit weights and a private address pointer into that store. On every multiply step it takes the signed 8-bit neuron state present on its input, multiplies it by the weight at the current pointer, adds the product into a signed local sum and advances the pointer. One neuron of a layer is therefore evaluated by streaming its input states past the cell while the weights are walked in order.

The cell never decides anything for itself. A central sequencer drives the same 2-bit command to every cell of a row, and the cell decodes it into clear, step, hold or rewind actions. Independently of the command, the input state is registered and presented on the state output one cycle later, so a row of cells forms a shift chain and each cell sees the stream one cycle after its left neighbour. A simple write port (enable, address, data) fills the weight store before a computation. The asynchronous active-low reset is released synchronously inside the block.

Top module: `nmac_pe`

## Requirements
- R1: While reset is asserted and after its release, until the first command takes effect, the state output and the sum read 0 and the weight pointer points at entry 0.
- R2: The state output equals the state input of the previous clock cycle whatever the command, one register of delay per cell.
- R3: Command code 2'b01 (clear) sets the sum to 0 and the weight pointer to 0 in the next cycle.
- R4: Command code 2'b10 (step) adds the signed product of the state input and the weight at the current pointer to the sum, and increments the pointer, both visible in the next cycle.
- R5: A step taken with the pointer at the last entry (DEPTH-1) moves the pointer back to entry 0.
- R6: Command code 2'b00 (hold) leaves the sum and the pointer unchanged.
- R7: Command code 2'b11 (rewind) sets the pointer to 0 and leaves the sum unchanged.
- R8: A write (enable high) stores the data at the given address at the clock edge; a step in a later cycle uses the new value, and the write itself changes neither the sum nor the pointer.
- R9: The sum is wide enough (STATE_W+WEIGHT_W+log2(DEPTH) bits) that DEPTH steps with the most extreme operands, for example -128 times -32768, give the exact signed result with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cmd_i | input | 2 | Command from the sequencer: 00 hold, 01 clear, 10 step, 11 rewind |
| state_i | input | STATE_W (8) | Signed neuron state from the left neighbour |
| state_o | output | STATE_W (8) | Registered copy of state_i for the right neighbour |
| acc_o | output | ACC_W (31) | Signed running sum of products |
| wr_en_i | input | 1 | Weight write enable |
| wr_addr_i | input | AW (7) | Weight write address |
| wr_data_i | input | WEIGHT_W (16) | Signed weight to store |

## Verification
On every cycle the assertions check the one-cycle state delay, the effect of each command on the pointer and the sum, the wrap of the pointer at the last entry, and the sum update of a step against the product of the state and the weight actually read. Whether the weights land at the right addresses, whether the pointer walks them in the right order over a whole pass, and whether the sum stays exact under extreme operands over a full pass can only be shown by the bench's scenarios, which compare the sum after every cycle against arithmetic computed from the written weights. The bench also sweeps all 256 state values against the extreme and mid-range weights.

// File: rtl/nmac_pkg.sv
package nmac_pkg;

  typedef enum logic [1:0] {
    CMD_HOLD   = 2'b00,
    CMD_CLEAR  = 2'b01,
    CMD_STEP   = 2'b10,
    CMD_REWIND = 2'b11
  } nmac_cmd_e;

  typedef struct packed {
    logic sum_clr;
    logic sum_add;
    logic ptr_zero;
    logic ptr_step;
  } nmac_ctl_t;

endpackage

// File: rtl/nmac_rst_sync.sv
module nmac_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);

  logic [1:0] sync_q;
  logic [1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= 2'b00;
    end else begin
      sync_q <= sync_d;
    end
  end

  assign srst_n = sync_q[1];

endmodule

// File: rtl/nmac_cmd_dec.sv
module nmac_cmd_dec
  import nmac_pkg::*;
(
  input  logic [1:0] cmd_i,
  output nmac_ctl_t  ctl_o
);

  always_comb begin
    ctl_o = '0;
    case (nmac_cmd_e'(cmd_i))
      CMD_CLEAR: begin
        ctl_o.sum_clr  = 1'b1;
        ctl_o.ptr_zero = 1'b1;
      end
      CMD_STEP: begin
        ctl_o.sum_add  = 1'b1;
        ctl_o.ptr_step = 1'b1;
      end
      CMD_REWIND: begin
        ctl_o.ptr_zero = 1'b1;
      end
      default: ctl_o = '0;
    endcase
  end

endmodule

// File: rtl/nmac_addr_gen.sv
module nmac_addr_gen #(
  parameter  int DEPTH = 128,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          srst_n,
  input  logic          ptr_zero_i,
  input  logic          ptr_step_i,
  output logic [AW-1:0] ptr_o
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [AW-1:0] ptr_q;
  logic [AW-1:0] ptr_d;
  logic          ptr_en;

  always_comb begin
    ptr_en = ptr_zero_i | ptr_step_i;
    if (ptr_zero_i) begin
      ptr_d = '0;
    end else if (ptr_q == LAST) begin
      ptr_d = '0;
    end else begin
      ptr_d = ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      ptr_q <= '0;
    end else if (ptr_en) begin
      ptr_q <= ptr_d;
    end
  end

  assign ptr_o = ptr_q;

endmodule

// File: rtl/nmac_wstore.sv
module nmac_wstore #(
  parameter  int DEPTH    = 128,
  parameter  int WEIGHT_W = 16,
  localparam int AW       = $clog2(DEPTH)
) (
  input  logic                clk,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [WEIGHT_W-1:0] wr_data_i,
  input  logic [AW-1:0]       rd_addr_i,
  output logic [WEIGHT_W-1:0] rd_data_o
);

  logic [WEIGHT_W-1:0] mem_q [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) begin
      mem_q[wr_addr_i] <= wr_data_i;
    end
  end

  always_comb begin
    rd_data_o = mem_q[rd_addr_i];
  end

endmodule

// File: rtl/nmac_mac.sv
module nmac_mac #(
  parameter  int STATE_W  = 8,
  parameter  int WEIGHT_W = 16,
  parameter  int ACC_W    = 31,
  localparam int PROD_W   = STATE_W + WEIGHT_W
) (
  input  logic                clk,
  input  logic                srst_n,
  input  logic                sum_clr_i,
  input  logic                sum_add_i,
  input  logic [STATE_W-1:0]  state_i,
  input  logic [WEIGHT_W-1:0] weight_i,
  output logic [ACC_W-1:0]    acc_o
);

  logic signed [PROD_W-1:0] prod;
  logic signed [ACC_W-1:0]  prod_ext;
  logic signed [ACC_W-1:0]  acc_q;
  logic signed [ACC_W-1:0]  acc_d;
  logic                     acc_en;

  always_comb begin
    prod     = $signed(state_i) * $signed(weight_i);
    prod_ext = ACC_W'(prod);
    acc_en   = sum_clr_i | sum_add_i;
    if (sum_clr_i) begin
      acc_d = '0;
    end else begin
      acc_d = acc_q + prod_ext;
    end
  end

  always_ff @(posedge clk or negedge srst_n) begin
    if (!srst_n) begin
      acc_q <= '0;
    end else if (acc_en) begin
      acc_q <= acc_d;
    end
  end

  assign acc_o = acc_q;

endmodule

// File: rtl/nmac_pe.sv
module nmac_pe
  import nmac_pkg::*;
#(
  parameter  int DEPTH    = 128,
  parameter  int STATE_W  = 8,
  parameter  int WEIGHT_W = 16,
  localparam int AW       = $clog2(DEPTH),
  localparam int ACC_W    = STATE_W + WEIGHT_W + AW
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [1:0]          cmd_i,
  input  logic [STATE_W-1:0]  state_i,
  output logic [STATE_W-1:0]  state_o,
  output logic [ACC_W-1:0]    acc_o,
  input  logic                wr_en_i,
  input  logic [AW-1:0]       wr_addr_i,
  input  logic [WEIGHT_W-1:0] wr_data_i
);

  logic                rst_sync_n;
  nmac_ctl_t           ctl;
  logic [AW-1:0]       rd_addr;
  logic [WEIGHT_W-1:0] rd_data;
  logic [STATE_W-1:0]  fwd_q;
  logic [STATE_W-1:0]  fwd_d;

  nmac_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (rst_sync_n)
  );

  nmac_cmd_dec u_dec (
    .cmd_i (cmd_i),
    .ctl_o (ctl)
  );

  nmac_addr_gen #(.DEPTH(DEPTH)) u_agen (
    .clk        (clk),
    .srst_n     (rst_sync_n),
    .ptr_zero_i (ctl.ptr_zero),
    .ptr_step_i (ctl.ptr_step),
    .ptr_o      (rd_addr)
  );

  nmac_wstore #(.DEPTH(DEPTH), .WEIGHT_W(WEIGHT_W)) u_wst (
    .clk       (clk),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  nmac_mac #(.STATE_W(STATE_W), .WEIGHT_W(WEIGHT_W), .ACC_W(ACC_W)) u_mac (
    .clk       (clk),
    .srst_n    (rst_sync_n),
    .sum_clr_i (ctl.sum_clr),
    .sum_add_i (ctl.sum_add),
    .state_i   (state_i),
    .weight_i  (rd_data),
    .acc_o     (acc_o)
  );

  // forward path to the right-hand neighbour
  always_comb begin
    fwd_d = state_i;
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      fwd_q <= '0;
    end else begin
      fwd_q <= fwd_d;
    end
  end

  assign state_o = fwd_q;

endmodule

// File: rtl/nmac_pe_chk.sv
module nmac_pe_chk #(
  parameter int DEPTH    = 128,
  parameter int STATE_W  = 8,
  parameter int WEIGHT_W = 16,
  parameter int AW       = 7,
  parameter int ACC_W    = 31
) (
  input logic                clk,
  input logic                srst_n,
  input logic [1:0]          cmd,
  input logic                wr_en,
  input logic [STATE_W-1:0]  state_i,
  input logic [STATE_W-1:0]  state_o,
  input logic [ACC_W-1:0]    acc,
  input logic [AW-1:0]       ptr,
  input logic [WEIGHT_W-1:0] weight
);

  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic signed [ACC_W-1:0] prod_chk;
  assign prod_chk = ACC_W'($signed(state_i) * $signed(weight));

  a_r2_forward: assert property (@(posedge clk) disable iff (!srst_n)
    1'b1 |=> state_o == $past(state_i));

  a_r3_clear: assert property (@(posedge clk) disable iff (!srst_n)
    cmd == 2'b01 |=> (acc == '0) && (ptr == '0));

  a_r4_ptr_step: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd == 2'b10) && (ptr != LAST) |=> ptr == AW'($past(ptr) + 1'b1));

  a_r4_sum_add: assert property (@(posedge clk) disable iff (!srst_n)
    cmd == 2'b10 |=> $signed(acc) == $signed(ACC_W'($past(acc) + $past(prod_chk))));

  a_r5_wrap: assert property (@(posedge clk) disable iff (!srst_n)
    (cmd == 2'b10) && (ptr == LAST) |=> ptr == '0);

  a_r6_hold: assert property (@(posedge clk) disable iff (!srst_n)
    cmd == 2'b00 |=> $stable(acc) && $stable(ptr));

  a_r7_rewind: assert property (@(posedge clk) disable iff (!srst_n)
    cmd == 2'b11 |=> (ptr == '0) && $stable(acc));

  a_r8_write_quiet: assert property (@(posedge clk) disable iff (!srst_n)
    wr_en && (cmd == 2'b00) |=> $stable(acc) && $stable(ptr));

endmodule

bind nmac_pe nmac_pe_chk #(
  .DEPTH(DEPTH), .STATE_W(STATE_W), .WEIGHT_W(WEIGHT_W), .AW(AW), .ACC_W(ACC_W)
) chk_i (
  .clk     (clk),
  .srst_n  (rst_sync_n),
  .cmd     (cmd_i),
  .wr_en   (wr_en_i),
  .state_i (state_i),
  .state_o (state_o),
  .acc     (acc_o),
  .ptr     (rd_addr),
  .weight  (rd_data)
);

// File: tb/nmac_pe_tb.sv
module nmac_pe_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 128;
  localparam int STATE_W    = 8;
  localparam int WEIGHT_W   = 16;
  localparam int AW         = $clog2(DEPTH);
  localparam int ACC_W      = STATE_W + WEIGHT_W + AW;

  localparam logic [1:0] C_HOLD   = 2'b00;
  localparam logic [1:0] C_CLEAR  = 2'b01;
  localparam logic [1:0] C_STEP   = 2'b10;
  localparam logic [1:0] C_REWIND = 2'b11;

  logic                clk;
  logic                rst_n;
  logic [1:0]          cmd;
  logic [STATE_W-1:0]  st_in;
  logic [STATE_W-1:0]  st_out;
  logic [ACC_W-1:0]    acc;
  logic                wen;
  logic [AW-1:0]       waddr;
  logic [WEIGHT_W-1:0] wdata;

  int     n_chk;
  int     n_fail;
  bit     done;
  longint m_w [DEPTH];
  longint m_acc;
  int     m_ptr;

  nmac_pe dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_i     (cmd),
    .state_i   (st_in),
    .state_o   (st_out),
    .acc_o     (acc),
    .wr_en_i   (wen),
    .wr_addr_i (waddr),
    .wr_data_i (wdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD / 2) clk = ~clk;

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic longint acc_val();
    return longint'($signed(acc));
  endfunction

  // one command cycle, then check sum and forwarded state
  task automatic cycle(input logic [1:0] c, input int s, input string req);
    @(negedge clk);
    cmd   = c;
    st_in = STATE_W'(s);
    wen   = 1'b0;
    case (c)
      C_CLEAR:  begin m_acc = 0; m_ptr = 0; end
      C_STEP:   begin m_acc = m_acc + longint'(s) * m_w[m_ptr]; m_ptr = (m_ptr + 1) % DEPTH; end
      C_REWIND: m_ptr = 0;
      default:  ;
    endcase
    @(posedge clk);
    #1;
    check(acc_val() == m_acc, req, acc_val(), m_acc);
    check(longint'($signed(st_out)) == longint'(s), "R2", longint'($signed(st_out)), longint'(s));
  endtask

  task automatic wr(input int a, input int w);
    @(negedge clk);
    cmd   = C_HOLD;
    wen   = 1'b1;
    waddr = AW'(a);
    wdata = WEIGHT_W'(w);
    m_w[a] = longint'(w);
    @(posedge clk);
    #1;
    check(acc_val() == m_acc, "R8", acc_val(), m_acc);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    n_chk = 0; n_fail = 0; done = 1'b0;
    m_acc = 0; m_ptr = 0;
    rst_n = 1'b0; cmd = C_STEP; st_in = 8'h5A; wen = 1'b0; waddr = '0; wdata = '0;
    repeat (4) @(negedge clk);
    // R1: outputs held at zero during reset even with activity on the inputs
    check(acc_val() == 0, "R1", acc_val(), 0);
    check(st_out == '0, "R1", longint'(st_out), 0);
    cmd = C_HOLD;
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check(acc_val() == 0, "R1", acc_val(), 0);

    // preload a computed weight pattern (R8)
    for (int i = 0; i < DEPTH; i++) begin
      int w = ((i * 7919 + 123) % 65536) - 32768;
      if (i == 1) w = 32767;
      if (i == 2) w = -32768;
      wr(i, w);
    end

    // R1: pointer starts at entry 0 without any clear
    cycle(C_STEP, 77, "R1");
    cycle(C_CLEAR, 3, "R3");

    // R4/R5: full pass and beyond, pointer wraps to entry 0
    for (int k = 0; k < DEPTH + 6; k++) begin
      cycle(C_STEP, ((k * 37 + 11) % 256) - 128, (k >= DEPTH) ? "R5" : "R4");
    end

    // R6: hold keeps the sum while states still ripple
    for (int k = 0; k < 5; k++) cycle(C_HOLD, k * 50 - 100, "R6");
    cycle(C_STEP, -3, "R6");

    // R7: rewind keeps the sum and restarts at entry 0
    cycle(C_REWIND, 9, "R7");
    cycle(C_STEP, 5, "R7");
    cycle(C_STEP, -7, "R7");

    // R8: overwrite the next entry mid-run, next step uses it
    wr(m_ptr, -12345);
    cycle(C_STEP, 100, "R8");

    // R4: sweep every state value against boundary weights at entry 0
    for (int j = 0; j < 4; j++) begin
      int wv = (j == 0) ? -32768 : (j == 1) ? 32767 : (j == 2) ? -1 : 12345;
      wr(0, wv);
      for (int s = -128; s < 128; s++) begin
        cycle(C_CLEAR, s, "R3");
        cycle(C_STEP, s, "R4");
      end
    end

    // R9: full pass with extreme operands, both signs
    for (int i = 0; i < DEPTH; i++) wr(i, -32768);
    cycle(C_CLEAR, 0, "R3");
    for (int k = 0; k < DEPTH; k++) cycle(C_STEP, -128, "R9");
    check(acc_val() == 64'sd536870912, "R9", acc_val(), 536870912);
    for (int i = 0; i < DEPTH; i++) wr(i, 32767);
    cycle(C_CLEAR, 0, "R3");
    for (int k = 0; k < DEPTH; k++) cycle(C_STEP, -128, "R9");
    check(acc_val() == -64'sd536854528, "R9", acc_val(), -536854528);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule